// File: doc/BRIEF.md
# Hard-Decision Viterbi Decoder, Rate 1/2, Constraint Length 7

This block recovers the information bits from a rate-1/2 convolutional code with constraint length 7 (64 trellis states), as used in OFDM wireless LAN baseband receivers. Each accepted input is one received pair of hard-decision code bits, which forms one trellis stage. Decoded bits leave the block one per cycle with a valid strobe, in bursts of one block length.

A small bank of add-compare-select (ACS) units is reused over several clock cycles to cover all 64 states of a stage. The path metrics sit in two register banks that swap roles after each stage. Every stage produces one 64-bit word of decisions, which goes into a circular survivor memory. Two traceback engines take turns on this memory. Each engine first walks back through a training window that it discards, then walks the block it decodes. It collects those bits newest-first, and a small last-in-first-out store turns them into chronological order.

Top module: `viterbi_dec`

## Requirements
- R1: The code uses generator 133 (octal) for `in_sym[1]` and generator 171 (octal) for `in_sym[0]`. Bit 6 of each generator taps the current input bit, and bit 0 taps the input from six stages earlier. The encoder starts in the all-zero state after reset.
- R2: After reset, `in_ready` is 1 and `out_valid` is 0. Once a symbol is accepted (`in_valid` and `in_ready` both high at a clock edge), `in_ready` stays 0 for exactly 16 cycles while four ACS units update the 64 states.
- R3: An error-free coded stream decodes to exactly the information bits that were encoded.
- R4: Isolated single-bit errors, spaced well apart in the received pairs, are corrected.
- R5: Decoded bits come out in chronological order, one per cycle, in bursts of 16. The first decoded bit is the first encoded bit. After N accepted stages, with N a multiple of 16 and at least 64, exactly (N/16 - 3) * 16 bits have been emitted.
- R6: No decoded bit is emitted until 64 stages (traceback depth 48 plus one block of 16) have been accepted.
- R7: Path metrics are 8-bit unsigned. When the smallest metric of a stage is 128 or more, 128 is subtracted from every metric in the next stage. Long streams with many corrected errors therefore decode correctly without metric overflow.
- R8: A reset in the middle of a stream discards all decoder state. The next stream decodes correctly from the all-zero state.
- R9: `in_valid` and `in_sym` have no effect while `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Received pair offered |
| in_ready | output | 1 | Decoder can accept a pair this cycle |
| in_sym | input | 2 | Received hard bits: [1] generator 133, [0] generator 171 |
| out_valid | output | 1 | Decoded bit valid |
| out_bit | output | 1 | Decoded information bit |

## Verification
The assertions rely on two assumptions about the input. First, errors are sparse enough that the surviving metrics stay within a narrow spread. This keeps the 8-bit sums and the 128 subtraction from wrapping. Second, input pairs arrive no faster than one block per 80 cycles, so a traceback engine is always idle when its turn comes. The stimulus meets both conditions: it waits for `in_ready` before every pair, which gives at least 17 cycles per stage, and it injects at most one flipped bit every 16 stages, never in the trailing flush stages.

// File: rtl/vit_pkg.sv
package vit_pkg;
   localparam int K  = 7;
   localparam int SW = K - 1;
   localparam int NS = 1 << SW;
   localparam logic [K-1:0] GEN_HI = 7'o133;
   localparam logic [K-1:0] GEN_LO = 7'o171;

   // w[0] is the current input bit, w[i] the input i stages earlier
   function automatic logic [1:0] code_pair(input logic [K-1:0] w);
      logic hi, lo;
      hi = 1'b0;
      lo = 1'b0;
      for (int i = 0; i < K; i++) begin
         hi ^= GEN_HI[K-1-i] & w[i];
         lo ^= GEN_LO[K-1-i] & w[i];
      end
      return {hi, lo};
   endfunction

   function automatic logic [1:0] hamming2(input logic [1:0] a, input logic [1:0] b);
      logic [1:0] x;
      x = a ^ b;
      return {x[1] & x[0], x[1] ^ x[0]};
   endfunction
endpackage

// File: rtl/vit_acs.sv
module vit_acs
   import vit_pkg::*;
#(
   parameter int PMW = 8
) (
   input  logic [1:0]     sym,
   input  logic [SW-1:0]  st,
   input  logic [PMW-1:0] pm0,
   input  logic [PMW-1:0] pm1,
   input  logic           sub,
   output logic [PMW-1:0] pm_out,
   output logic           dec,
   output logic           ovf
);
   localparam int HALF = 1 << (PMW - 1);

   logic [1:0]   bm0, bm1;
   logic [PMW:0] off, a0, a1;

   always_comb begin
      bm0 = hamming2(code_pair({1'b0, st}), sym);
      bm1 = hamming2(code_pair({1'b1, st}), sym);
      off = sub ? (PMW+1)'(HALF) : '0;
      a0  = {1'b0, pm0} + (PMW+1)'(bm0) - off;
      a1  = {1'b0, pm1} + (PMW+1)'(bm1) - off;
      dec = (a1 < a0);
      pm_out = dec ? a1[PMW-1:0] : a0[PMW-1:0];
      ovf = a0[PMW] | a1[PMW];
   end
endmodule

// File: rtl/vit_tb.sv
module vit_tb
   import vit_pkg::*;
#(
   parameter int AW    = 7,
   parameter int DEPTH = 48,
   parameter int BLK   = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   output logic [AW-1:0] rd_addr,
   input  logic [NS-1:0] rd_word,
   output logic          out_valid,
   output logic          out_bit
);
   localparam int STEPS = DEPTH + BLK;
   localparam int SCW   = $clog2(STEPS + 1);
   localparam int BW    = $clog2(BLK);

   logic           tracing, popping;
   logic [SCW-1:0] step;
   logic [AW-1:0]  addr;
   logic [SW-1:0]  st;
   logic [BLK-1:0] lifo;
   logic [BW-1:0]  pop_idx;

   assign rd_addr   = addr;
   assign out_valid = popping;
   assign out_bit   = lifo[pop_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tracing <= 1'b0;
         popping <= 1'b0;
         step    <= '0;
         addr    <= '0;
         st      <= '0;
         lifo    <= '0;
         pop_idx <= '0;
      end else begin
         if (start) begin
            tracing <= 1'b1;
            step    <= '0;
            addr    <= start_addr;
            st      <= '0;
         end else if (tracing) begin
            if (step >= SCW'(DEPTH))
               lifo[BW'(step - SCW'(DEPTH))] <= st[0];
            st   <= {rd_word[st], st[SW-1:1]};
            addr <= addr - 1'b1;
            step <= step + 1'b1;
            if (step == SCW'(STEPS - 1)) begin
               tracing <= 1'b0;
               popping <= 1'b1;
               pop_idx <= BW'(BLK - 1);
            end
         end
         if (popping) begin
            pop_idx <= pop_idx - 1'b1;
            if (pop_idx == '0) popping <= 1'b0;
         end
      end
   end

   assert_engine_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !(tracing || popping));
   assert_phase_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(tracing && popping));
endmodule

// File: rtl/viterbi_dec.sv
module viterbi_dec
   import vit_pkg::*;
#(
   parameter int PMW       = 8,
   parameter int NACS      = 4,
   parameter int TB_DEPTH  = 48,
   parameter int BLK       = 16,
   parameter int MEM_DEPTH = 128,
   parameter int NTB       = 2,
   parameter int PM_INIT   = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic [1:0] in_sym,
   output logic       out_valid,
   output logic       out_bit
);
   localparam int CYC  = NS / NACS;
   localparam int CW   = $clog2(CYC);
   localparam int AW   = $clog2(MEM_DEPTH);
   localparam int BW   = $clog2(BLK);
   localparam int CAP  = TB_DEPTH + BLK - 1;
   localparam int TW   = $clog2(CAP + 1);
   localparam int SELW = $clog2(NTB);
   localparam int HALF = 1 << (PMW - 1);

   generate
      if (TB_DEPTH % BLK != 0) begin : g_chk_depth
         $error("TB_DEPTH must be a multiple of BLK");
      end
      if (MEM_DEPTH < TB_DEPTH + 2 * BLK || (1 << AW) != MEM_DEPTH) begin : g_chk_mem
         $error("MEM_DEPTH must be a power of two covering TB_DEPTH + 2*BLK");
      end
      if (NACS < 2 || NS % NACS != 0) begin : g_chk_acs
         $error("NACS must divide the state count and be at least 2");
      end
      if (NTB < 2 || (1 << SELW) != NTB) begin : g_chk_ntb
         $error("NTB must be a power of two, at least 2");
      end
      if (PM_INIT >= HALF) begin : g_chk_init
         $error("PM_INIT must stay below half the metric range");
      end
   endgenerate

   logic           run, bank, sub_q;
   logic [CW-1:0]  cyc;
   logic [1:0]     sym_q;
   logic [PMW-1:0] min_q, stage_min;
   logic [PMW-1:0] pm [2][NS];
   logic [NS-1:0]  sv_q, sv_full;
   logic [NS-1:0]  mem [MEM_DEPTH];
   logic [AW-1:0]  wp;
   logic [BW-1:0]  blk;
   logic [TW-1:0]  tot;
   logic [SELW-1:0] tb_sel;
   logic           commit, trig;

   logic [SW-1:0]  st_u   [NACS];
   logic [PMW-1:0] acs_pm [NACS];
   logic           acs_dec[NACS];
   logic           acs_ovf[NACS];

   assign in_ready = !run;
   assign commit   = run && (cyc == CW'(CYC - 1));
   assign trig     = commit && (blk == BW'(BLK - 1)) && (tot == TW'(CAP));

   // ACS bank: unit u serves state cyc*NACS+u in this cycle
   for (genvar u = 0; u < NACS; u++) begin : g_acs
      assign st_u[u] = SW'(int'(cyc) * NACS + u);
      vit_acs #(.PMW(PMW)) u_acs (
         .sym    (sym_q),
         .st     (st_u[u]),
         .pm0    (pm[bank][{1'b0, st_u[u][SW-1:1]}]),
         .pm1    (pm[bank][{1'b1, st_u[u][SW-1:1]}]),
         .sub    (sub_q),
         .pm_out (acs_pm[u]),
         .dec    (acs_dec[u]),
         .ovf    (acs_ovf[u])
      );
      assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
         run |-> !acs_ovf[u]);
   end

   always_comb begin
      stage_min = (cyc == '0) ? '1 : min_q;
      sv_full   = sv_q;
      for (int u = 0; u < NACS; u++) begin
         if (acs_pm[u] < stage_min) stage_min = acs_pm[u];
         sv_full[st_u[u]] = acs_dec[u];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= 1'b0;
         bank   <= 1'b0;
         sub_q  <= 1'b0;
         cyc    <= '0;
         sym_q  <= '0;
         min_q  <= '0;
         sv_q   <= '0;
         wp     <= '0;
         blk    <= '0;
         tot    <= '0;
         tb_sel <= '0;
         for (int s = 0; s < NS; s++) begin
            pm[0][s] <= (s == 0) ? '0 : PMW'(PM_INIT);
            pm[1][s] <= '0;
         end
      end else if (!run) begin
         if (in_valid) begin
            run   <= 1'b1;
            cyc   <= '0;
            sym_q <= in_sym;
         end
      end else begin
         for (int u = 0; u < NACS; u++)
            pm[~bank][st_u[u]] <= acs_pm[u];
         sv_q <= sv_full;
         if (commit) begin
            run   <= 1'b0;
            bank  <= ~bank;
            sub_q <= (stage_min >= PMW'(HALF));
            wp    <= wp + 1'b1;
            blk   <= (blk == BW'(BLK - 1)) ? '0 : blk + 1'b1;
            tot   <= (tot == TW'(CAP)) ? tot : tot + 1'b1;
            if (trig) tb_sel <= tb_sel + 1'b1;
         end else begin
            cyc   <= cyc + 1'b1;
            min_q <= stage_min;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (commit) mem[wp] <= sv_full;
   end

   // Alternating traceback engines
   logic [AW-1:0] eng_addr [NTB];
   logic [NS-1:0] eng_word [NTB];
   logic [NTB-1:0] eng_ov, eng_ob;

   for (genvar e = 0; e < NTB; e++) begin : g_tb
      assign eng_word[e] = mem[eng_addr[e]];
      vit_tb #(.AW(AW), .DEPTH(TB_DEPTH), .BLK(BLK)) u_tb (
         .clk        (clk),
         .rst_n      (rst_n),
         .start      (trig && (tb_sel == SELW'(e))),
         .start_addr (wp),
         .rd_addr    (eng_addr[e]),
         .rd_word    (eng_word[e]),
         .out_valid  (eng_ov[e]),
         .out_bit    (eng_ob[e])
      );
   end

   assign out_valid = |eng_ov;
   assign out_bit   = |(eng_ov & eng_ob);

   assert_one_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(eng_ov) <= 1);
   assert_ready_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);
   assert_quiet_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tot != TW'(CAP)) |-> !out_valid);
endmodule

// File: tb/viterbi_dec_tb.sv
module viterbi_dec_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [1:0] in_sym = 2'b00;
   logic       in_ready, out_valid, out_bit;

   int n_checks = 0;
   int n_fail   = 0;
   int n_tx     = 0;
   int n_rx     = 0;
   logic exp_bits [0:4095];
   logic got_bits [0:4095];
   logic [6:0]  hist = '0;
   logic [15:0] lfsr = 16'hACE1;

   localparam logic [6:0] GA = 7'o133;
   localparam logic [6:0] GB = 7'o171;

   always #2.5 clk = ~clk;

   viterbi_dec u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_sym(in_sym), .out_valid(out_valid), .out_bit(out_bit)
   );

   always @(negedge clk) begin
      if (!rst_n) n_rx = 0;
      else if (out_valid) begin
         if (n_rx < 4096) got_bits[n_rx] = out_bit;
         n_rx = n_rx + 1;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      in_valid = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      hist = '0;
      n_tx = 0;
      @(negedge clk);
   endtask

   task automatic send_bit(input logic b, input logic [1:0] flip, input bit garble);
      logic [1:0] pair;
      hist = {hist[5:0], b};
      pair = '0;
      for (int i = 0; i < 7; i++) begin
         pair[1] ^= GA[6-i] & hist[i];
         pair[0] ^= GB[6-i] & hist[i];
      end
      if (n_tx < 4096) exp_bits[n_tx] = b;
      n_tx++;
      while (!in_ready) begin
         in_valid = garble;
         in_sym   = ~pair;
         @(negedge clk);
      end
      in_valid = 1'b1;
      in_sym   = pair ^ flip;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   function automatic logic next_data();
      logic fb;
      fb   = lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5];
      lfsr = {fb, lfsr[15:1]};
      return lfsr[0];
   endfunction

   // ndata + 64 flush zeros; errors every err_per stages (0 = none)
   task automatic run_stream(input string req, input int ndata, input int err_per, input bit garble);
      int ntot, exp_n, mism, first_bad;
      ntot = ndata + 64;
      for (int k = 0; k < ntot; k++) begin
         logic [1:0] fl;
         fl = 2'b00;
         if (err_per > 0 && k < ndata && k % err_per == err_per / 2)
            fl = (k % 2 == 0) ? 2'b10 : 2'b01;
         send_bit((k < ndata) ? next_data() : 1'b0, fl, garble);
      end
      repeat (300) @(negedge clk);
      exp_n = (ntot / 16 - 3) * 16;
      check(req, "decoded bit count", n_rx, exp_n);
      mism = 0;
      first_bad = -1;
      for (int k = 0; k < exp_n && k < n_rx; k++)
         if (got_bits[k] !== exp_bits[k]) begin
            mism++;
            if (first_bad < 0) first_bad = k;
         end
      if (first_bad >= 0)
         $display("  first mismatch at bit %0d: actual %0d expected %0d",
                  first_bad, got_bits[first_bad], exp_bits[first_bad]);
      check(req, "mismatching bits", mism, 0);
   endtask

   task automatic test_reset_state();
      do_reset();
      check("R2", "in_ready after reset", int'(in_ready), 1);
      check("R2", "out_valid after reset", int'(out_valid), 0);
   endtask

   task automatic test_ready_window();
      int lows;
      do_reset();
      in_valid = 1'b1;
      in_sym   = 2'b00;
      @(negedge clk);
      in_valid = 1'b0;
      lows = 0;
      while (!in_ready && lows < 40) begin
         lows++;
         @(negedge clk);
      end
      check("R2", "cycles with in_ready low", lows, 16);
   endtask

   task automatic test_clean();
      do_reset();
      run_stream("R3", 128, 0, 1'b0);
      check("R5", "first decoded bit", int'(got_bits[0]), int'(exp_bits[0]));
      check("R1", "decoded bit 17", int'(got_bits[17]), int'(exp_bits[17]));
   endtask

   task automatic test_quiet();
      do_reset();
      for (int k = 0; k < 63; k++) send_bit(next_data(), 2'b00, 1'b0);
      repeat (200) @(negedge clk);
      check("R6", "bits out after 63 stages", n_rx, 0);
      send_bit(next_data(), 2'b00, 1'b0);
      repeat (200) @(negedge clk);
      check("R6", "bits out after 64 stages", n_rx, 16);
   endtask

   task automatic test_errors();
      do_reset();
      run_stream("R4", 256, 24, 1'b0);
   endtask

   task automatic test_normalise();
      do_reset();
      run_stream("R7", 2944, 16, 1'b0);
   endtask

   task automatic test_busy_ignored();
      do_reset();
      run_stream("R9", 128, 0, 1'b1);
   endtask

   task automatic test_mid_reset();
      do_reset();
      for (int k = 0; k < 40; k++) send_bit(next_data(), 2'b00, 1'b0);
      in_valid = 1'b1;
      in_sym   = 2'b11;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (5) @(negedge clk);
      do_reset();
      run_stream("R8", 128, 0, 1'b0);
   endtask

   initial begin
      test_reset_state();
      test_ready_window();
      test_clean();
      test_quiet();
      test_errors();
      test_normalise();
      test_busy_ignored();
      test_mid_reset();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule